// File: doc/BRIEF.md
# Periodic Sample-and-Compare Wake Controller

This block keeps an analog sensor path asleep for most of the time. A free-running period timer issues a tick every programmed number of cycles. Each tick moves the controller out of sleep. It powers up an external converter and lets it settle for a programmable number of cycles. It then requests exactly one conversion and waits for the converter's done strobe.

The captured sample is compared with a stored reference value as an unsigned absolute difference. If the difference is strictly greater than the programmed threshold, a one-cycle wake pulse is sent to the rest of the system and the reference takes the new sample. In every case the converter is switched off again and the controller returns to sleep. The first conversion after reset only primes the reference. The value most recently captured is always visible on a status output.

The controller runs through five named states. SLEEP waits for a tick (transition SLEEP→SETTLE). SETTLE holds the converter enabled while the settle count runs (SETTLE→START). START drives the conversion request for one cycle (START→WAIT). WAIT holds until done (WAIT→EVAL). EVAL decides on a wake and goes back unconditionally (EVAL→SLEEP). A longer tick period means fewer converter power-ups, at the cost of a longer worst-case detection latency.

Top module: `sample_wake_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, conv_en, conv_start and wake_pulse are low and last_sample is 0.
- R2: Only a timer tick moves the controller out of SLEEP, and conv_en is low in SLEEP. Ticks occur every cfg_period cycles (a value of 0 or 1 means every cycle). When the sampling cycle is shorter than the period, successive rising edges of conv_en are exactly cfg_period cycles apart.
- R3: After a tick, conv_en is high for exactly cfg_settle+1 cycles before conv_start is raised. conv_start is high for exactly one cycle, and conv_en is high during it.
- R4: conv_done is accepted only in WAIT. A conv_done pulse in any other state has no effect on last_sample.
- R5: last_sample is updated with conv_data in the cycle after conv_done is accepted, and holds that value until the next accepted sample.
- R6: The first sample accepted after reset only loads the reference and never produces a wake pulse.
- R7: A wake pulse is produced when |sample − reference| > cfg_thresh, using unsigned DATA_W-bit values, for samples both above and below the reference. A difference equal to the threshold does not wake.
- R8: On a wake, the reference becomes the new sample. Without a wake, the reference keeps its previous value.
- R9: wake_pulse is high for exactly one cycle, in the EVAL cycle that follows the accepted conv_done. conv_en is already low in that cycle, and the controller is back in SLEEP in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_period | input | PERIOD_W | Tick period in cycles |
| cfg_thresh | input | DATA_W | Change threshold (strictly exceeded to wake) |
| cfg_settle | input | SETTLE_W | Extra settle cycles between enable and start |
| conv_en | output | 1 | Converter power enable |
| conv_start | output | 1 | One-cycle conversion request |
| conv_done | input | 1 | Conversion complete strobe |
| conv_data | input | DATA_W | Conversion result, valid with conv_done |
| wake_pulse | output | 1 | One-cycle wake event to the system |
| last_sample | output | DATA_W | Most recently accepted sample |

## Verification
The bench uses the default widths: 10-bit data, a 16-bit period field and an 8-bit settle field. It programs short periods of 20 and 50 cycles, so that many complete sleep-sample-sleep rounds fit in a short run and the spacing between ticks can be measured exactly. Settle values of 3 and 0 cover a normal settle window and the shortest one. Thresholds of 10 and 0 bring the equal-to-threshold boundary, both directions of change and the smallest possible change within reach.

// File: rtl/swk_pkg.sv
package swk_pkg;

    typedef enum logic [2:0] {
        ST_SLEEP,
        ST_SETTLE,
        ST_START,
        ST_WAIT,
        ST_EVAL
    } swk_state_t;

endpackage

// File: rtl/swk_tick.sv
module swk_tick #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] period,
    output logic                tick
);

    localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

    logic [PERIOD_W-1:0] cnt;

    always_comb begin
        tick = (period <= ONE) || (cnt >= period - ONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + ONE;
        end
    end

    // A period above one never yields ticks on consecutive cycles.
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && period > ONE && $stable(period)) |=> !tick);

endmodule

// File: rtl/swk_delta.sv
module swk_delta #(
    parameter int DATA_W = 10
) (
    input  logic [DATA_W-1:0] sample,
    input  logic [DATA_W-1:0] ref_val,
    input  logic [DATA_W-1:0] thresh,
    output logic [DATA_W-1:0] delta,
    output logic              over
);

    always_comb begin
        if (sample >= ref_val) begin
            delta = sample - ref_val;
        end else begin
            delta = ref_val - sample;
        end
        over = delta > thresh;
    end

endmodule

// File: rtl/swk_seq.sv
module swk_seq
    import swk_pkg::*;
#(
    parameter int DATA_W   = 10,
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [SETTLE_W-1:0] cfg_settle,
    input  logic                conv_done,
    input  logic [DATA_W-1:0]   conv_data,
    input  logic                over,
    output logic                conv_en,
    output logic                conv_start,
    output logic                wake_pulse,
    output logic [DATA_W-1:0]   sample_q,
    output logic [DATA_W-1:0]   ref_q
);

    swk_state_t          state;
    swk_state_t          state_nx;
    logic [SETTLE_W-1:0] settle_cnt;
    logic                primed;
    logic                eval;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SLEEP:  if (tick) state_nx = ST_SETTLE;
            ST_SETTLE: if (settle_cnt >= cfg_settle) state_nx = ST_START;
            ST_START:  state_nx = ST_WAIT;
            ST_WAIT:   if (conv_done) state_nx = ST_EVAL;
            ST_EVAL:   state_nx = ST_SLEEP;
            default:   state_nx = ST_SLEEP;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_SLEEP;
        end else begin
            state <= state_nx;
        end
    end

    // Moore outputs
    always_comb begin
        conv_en    = 1'b0;
        conv_start = 1'b0;
        eval       = 1'b0;
        unique case (state)
            ST_SLEEP:  ;
            ST_SETTLE: conv_en = 1'b1;
            ST_START: begin
                conv_en    = 1'b1;
                conv_start = 1'b1;
            end
            ST_WAIT:   conv_en = 1'b1;
            ST_EVAL:   eval = 1'b1;
            default:   ;
        endcase
        wake_pulse = eval && primed && over;
    end

    // settle counter, sample capture and reference
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            settle_cnt <= '0;
            sample_q   <= '0;
            ref_q      <= '0;
            primed     <= 1'b0;
        end else begin
            if (state == ST_SETTLE) begin
                settle_cnt <= settle_cnt + SETTLE_W'(1);
            end else begin
                settle_cnt <= '0;
            end
            if (state == ST_WAIT && conv_done) begin
                sample_q <= conv_data;
            end
            if (eval) begin
                if (!primed) begin
                    ref_q  <= sample_q;
                    primed <= 1'b1;
                end else if (over) begin
                    ref_q <= sample_q;
                end
            end
        end
    end

    assert_sleep_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && !tick) |=> state == ST_SLEEP);

    assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> (!conv_start && conv_en));

    assert_done_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(state == ST_WAIT && conv_done) |=> $stable(sample_q));

    assert_first_no_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !primed |-> !wake_pulse);

    assert_ref_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_pulse || (eval && !primed)) |=> ref_q == $past(sample_q));

    assert_ref_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !wake_pulse) |=> $stable(ref_q));

    assert_wake_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> (!wake_pulse && !conv_en && state == ST_SLEEP));

endmodule

// File: rtl/sample_wake_ctrl.sv
module sample_wake_ctrl #(
    parameter int DATA_W   = 10,
    parameter int PERIOD_W = 16,
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] cfg_period,
    input  logic [DATA_W-1:0]   cfg_thresh,
    input  logic [SETTLE_W-1:0] cfg_settle,
    output logic                conv_en,
    output logic                conv_start,
    input  logic                conv_done,
    input  logic [DATA_W-1:0]   conv_data,
    output logic                wake_pulse,
    output logic [DATA_W-1:0]   last_sample
);

    logic              tick;
    logic              over;
    logic [DATA_W-1:0] delta;
    logic [DATA_W-1:0] sample_q;
    logic [DATA_W-1:0] ref_q;

    swk_tick #(.PERIOD_W(PERIOD_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .period (cfg_period),
        .tick   (tick)
    );

    swk_delta #(.DATA_W(DATA_W)) u_delta (
        .sample  (sample_q),
        .ref_val (ref_q),
        .thresh  (cfg_thresh),
        .delta   (delta),
        .over    (over)
    );

    swk_seq #(.DATA_W(DATA_W), .SETTLE_W(SETTLE_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .cfg_settle (cfg_settle),
        .conv_done  (conv_done),
        .conv_data  (conv_data),
        .over       (over),
        .conv_en    (conv_en),
        .conv_start (conv_start),
        .wake_pulse (wake_pulse),
        .sample_q   (sample_q),
        .ref_q      (ref_q)
    );

    assign last_sample = sample_q;

    // A wake needs a change beyond the threshold between sample and reference.
    assert_wake_delta_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> (delta > cfg_thresh && sample_q != ref_q));

    // Converter stays off while no tick has been seen since sleep (R2).
    assert_enable_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_en && !tick) |=> !conv_en);

endmodule

// File: tb/tb_sample_wake_ctrl.sv
module tb_sample_wake_ctrl;

    localparam int DATA_W   = 10;
    localparam int PERIOD_W = 16;
    localparam int SETTLE_W = 8;

    logic                clk = 1'b0;
    logic                rst_n;
    logic [PERIOD_W-1:0] cfg_period;
    logic [DATA_W-1:0]   cfg_thresh;
    logic [SETTLE_W-1:0] cfg_settle;
    logic                conv_en;
    logic                conv_start;
    logic                conv_done;
    logic [DATA_W-1:0]   conv_data;
    logic                wake_pulse;
    logic [DATA_W-1:0]   last_sample;

    int n_checks = 0;
    int n_fails  = 0;

    logic [DATA_W-1:0] next_data = '0;
    logic              resp_pend = 1'b0;
    logic              stray_arm = 1'b0;
    logic              stray_used = 1'b0;

    always #5 clk = ~clk;

    sample_wake_ctrl #(
        .DATA_W(DATA_W), .PERIOD_W(PERIOD_W), .SETTLE_W(SETTLE_W)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_period(cfg_period), .cfg_thresh(cfg_thresh), .cfg_settle(cfg_settle),
        .conv_en(conv_en), .conv_start(conv_start),
        .conv_done(conv_done), .conv_data(conv_data),
        .wake_pulse(wake_pulse), .last_sample(last_sample)
    );

    // converter model: done one cycle after a start; optional stray done in settle
    always @(negedge clk) begin
        if (!rst_n) begin
            conv_done <= 1'b0;
            conv_data <= '0;
            resp_pend <= 1'b0;
        end else if (resp_pend) begin
            conv_done <= 1'b1;
            conv_data <= next_data;
            resp_pend <= 1'b0;
        end else if (stray_arm && !stray_used && conv_en && !conv_start) begin
            conv_done  <= 1'b1;
            conv_data  <= 10'd999;
            stray_used <= 1'b1;
        end else begin
            conv_done <= 1'b0;
            if (conv_start) resp_pend <= 1'b1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic test_reset();
        rst_n      = 1'b0;
        cfg_period = 16'd20;
        cfg_thresh = 10'd10;
        cfg_settle = 8'd3;
        repeat (4) @(negedge clk);
        check(!conv_en && !conv_start && !wake_pulse, "R1 outputs in reset",
              int'({conv_en, conv_start, wake_pulse}), 0);
        check(last_sample == 0, "R1 last_sample in reset", int'(last_sample), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!conv_start && !wake_pulse && last_sample == 0, "R1 after reset",
              int'(last_sample), 0);
    endtask

    // One full sampling round; checks settle length, capture, wake and return.
    task automatic run_sample(input logic [DATA_W-1:0] data, input bit exp_wake,
                              input int exp_settle, input string req);
        int en_cnt = 0;
        int guard  = 0;
        logic [DATA_W-1:0] prev = last_sample;
        next_data = data;
        while (1) begin
            @(negedge clk);
            if (conv_start) break;
            if (conv_en) en_cnt++;
            guard++;
            if (guard > 2000) break;
        end
        check(conv_start === 1'b1, "R2 tick started a round", int'(conv_start), 1);
        check(en_cnt == exp_settle, "R3 settle length", en_cnt, exp_settle);
        check(last_sample == prev, "R4 no capture before start", int'(last_sample), int'(prev));
        @(negedge clk);
        check(!conv_start && conv_en, "R3 start single cycle",
              int'({conv_start, conv_en}), 1);
        @(negedge clk);
        check(wake_pulse == exp_wake, req, int'(wake_pulse), int'(exp_wake));
        check(last_sample == data, "R5 captured sample", int'(last_sample), int'(data));
        check(!conv_en, "R9 enable off in eval", int'(conv_en), 0);
        @(negedge clk);
        check(!wake_pulse && !conv_en, "R9 single pulse and sleep",
              int'({wake_pulse, conv_en}), 0);
    endtask

    task automatic test_period(input int p);
        int gap   = 0;
        int guard = 0;
        logic prev_en;
        cfg_period = PERIOD_W'(p);
        cfg_thresh = 10'd1023;
        next_data  = last_sample;
        // skip first rise after the change
        prev_en = conv_en;
        while (guard < 2000) begin
            @(negedge clk); guard++;
            if (conv_en && !prev_en) break;
            prev_en = conv_en;
        end
        prev_en = conv_en;
        while (guard < 2000) begin
            @(negedge clk); guard++;
            if (conv_en && !prev_en) break;
            prev_en = conv_en;
        end
        prev_en = conv_en;
        while (guard < 2000) begin
            @(negedge clk); guard++; gap++;
            if (conv_en && !prev_en) break;
            prev_en = conv_en;
        end
        check(gap == p, "R2 tick spacing", gap, p);
    endtask

    initial begin
        rst_n     = 1'b0;
        test_reset();
        // R6: first sample only primes (reference 500)
        run_sample(10'd500, 1'b0, 4, "R6 first sample no wake");
        // R7: diff 8 below threshold 10
        run_sample(10'd508, 1'b0, 4, "R7 small change no wake");
        // R7: diff exactly 10 does not wake
        run_sample(10'd510, 1'b0, 4, "R7 equal to threshold no wake");
        // R8: reference still 500, so 516 wakes (diff 16)
        run_sample(10'd516, 1'b1, 4, "R8 reference held then wake");
        // R8/R7: reference now 516, 505 below by 11 wakes
        run_sample(10'd505, 1'b1, 4, "R7 downward change wakes");
        // R4: stray done during settle is ignored
        stray_arm = 1'b1;
        run_sample(10'd505, 1'b0, 4, "R4 stray done ignored");
        check(stray_used, "R4 stray done was driven", int'(stray_used), 1);
        stray_arm = 1'b0;
        // R3: zero settle gives one enabled cycle before start
        cfg_settle = 8'd0;
        run_sample(10'd505, 1'b0, 1, "R3 zero settle no wake");
        // R7: threshold 0, change of 1 wakes
        cfg_thresh = 10'd0;
        run_sample(10'd506, 1'b1, 1, "R7 threshold zero wakes");
        cfg_settle = 8'd3;
        test_period(50);
        test_period(20);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #1000000;
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule